// File: doc/BRIEF.md
# Read-Priority Request Reorder Unit

This unit sits in front of one rank's FIFO command queue in a memory controller. It collects a set of requests bound for that rank, each with a kind (read or write), an address and a tag, and sends them out again in an order that favours reads. Reads therefore reach the rank sooner. A read-after-write dependence on the same address is never broken, because each read takes with it every older write to its address that no earlier read has already claimed.

Requests are loaded one per accepted input beat until the set is closed, either by a last-entry flag or because the storage is full. The unit then streams the reordered set through a valid/ready output and marks the final entry. Each read, in arrival order, leads a group made of its claimed writes in arrival order with the read placed last. The groups are emitted in the order their reads arrived. Writes claimed by no read follow all groups, in arrival order. The address match looks only at the low `CMP_W` bits. A narrow compare can therefore pull extra writes into a group, but it never misses a real match. A new set is taken only once the previous one has been fully sent.

Top module: `rd_first_reorder`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: A read is never emitted before any older write of the same set whose low `CMP_W` address bits equal its own.
- R3: A read's group holds every older write with matching low address bits that no earlier read has claimed. The group is emitted in arrival order, with the read last.
- R4: Groups are emitted in the arrival order of the reads that lead them. A set of reads only is therefore emitted unchanged.
- R5: Writes that belong to no group are emitted after the last group, in arrival order.
- R6: A set without reads is emitted in arrival order, unchanged.
- R7: Address matching uses only bits `[CMP_W-1:0]`. Writes whose low bits match a later read join its group even when their upper bits differ.
- R8: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outTag`, `outAddr`, `outIsRead` and `outLast` stay stable.
- R9: `inReady` is 0 from the cycle after a set closes until the handshake of its final output. `outLast` is 1 exactly on that final output.
- R10: A set closes on an accepted entry with `inLast` = 1, or on the `DEPTH`-th accepted entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input entry valid |
| inReady | output | 1 | Unit accepts an entry |
| inIsRead | input | 1 | 1 = read, 0 = write |
| inAddr | input | ADDR_W | Request address |
| inTag | input | TAG_W | Request tag |
| inLast | input | 1 | Entry closes the set |
| outValid | output | 1 | Output entry valid |
| outReady | input | 1 | Downstream queue accepts |
| outIsRead | output | 1 | 1 = read, 0 = write |
| outAddr | output | ADDR_W | Address of emitted entry |
| outTag | output | TAG_W | Tag of emitted entry |
| outLast | output | 1 | Final entry of the set |

## Verification
The assertions assume that the input follows the handshake: fields are meaningful only while `inValid` is high, and a set ends with `inLast` or at `DEPTH` entries. They also assume that `outReady` may stall at any time. The bench changes inputs only on the falling edge and holds each entry until `inReady` is seen. It lets `outReady` go high only while sampling outputs one at a time, and it holds `outReady` low for several cycles to exercise the stall hold. Tags are unique within each set, so the emitted order can be checked by tag alone.

// File: rtl/rfo_pkg.sv
package rfo_pkg;
  typedef struct packed {
    logic load;
    logic emit;
    logic clear;
  } rfStrobe_t;

  typedef enum logic {ST_LOAD, ST_EMIT} rfState_t;
endpackage

// File: rtl/rfo_ctrl.sv
module rfo_ctrl
  import rfo_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      outReady,
  input  logic      fullNext,
  input  logic      lastLeft,
  output logic      inReady,
  output logic      outValid,
  output logic      outLast,
  output rfStrobe_t stb
);
  rfState_t state, stateNext;

  assign inReady  = (state == ST_LOAD);
  assign outValid = (state == ST_EMIT);
  assign outLast  = outValid & lastLeft;

  always_comb begin
    stb.load  = inValid & inReady;
    stb.emit  = outValid & outReady;
    stb.clear = stb.emit & lastLeft;
  end

  always_comb begin
    stateNext = state;
    if (state == ST_LOAD && stb.load && (inLast || fullNext)) stateNext = ST_EMIT;
    if (state == ST_EMIT && stb.clear) stateNext = ST_LOAD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_LOAD;
    else       state <= stateNext;
  end
endmodule

// File: rtl/rfo_datapath.sv
module rfo_datapath
  import rfo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 4,
  parameter int CMP_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobe_t         stb,
  input  logic              inIsRead,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [TAG_W-1:0]  inTag,
  output logic              fullNext,
  output logic              lastLeft,
  output logic              outIsRead,
  output logic [ADDR_W-1:0] outAddr,
  output logic [TAG_W-1:0]  outTag
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int GRP_W = IDX_W + 1;
  localparam int KEY_W = GRP_W + IDX_W;

  logic              isRd [DEPTH];
  logic [ADDR_W-1:0] addr [DEPTH];
  logic [TAG_W-1:0]  tag  [DEPTH];
  logic [DEPTH-1:0]  done;
  logic [CNT_W-1:0]  count, emitCnt;

  // group leader of each entry: itself for a read, the earliest younger
  // matching read for a write, DEPTH when unclaimed
  logic [GRP_W-1:0] grp [DEPTH];
  logic [IDX_W-1:0] selIdx;
  logic             selFound;
  logic [KEY_W-1:0] bestKey;

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      grp[j] = GRP_W'(DEPTH);
      if (isRd[j]) grp[j] = GRP_W'(j);
      else begin
        for (int k = DEPTH - 1; k > j; k--) begin
          if (CNT_W'(k) < count && isRd[k] &&
              addr[k][CMP_W-1:0] == addr[j][CMP_W-1:0])
            grp[j] = GRP_W'(k);
        end
      end
    end
  end

  always_comb begin
    selFound = 1'b0;
    selIdx   = '0;
    bestKey  = '1;
    for (int j = 0; j < DEPTH; j++) begin
      if (CNT_W'(j) < count && !done[j] &&
          (!selFound || {grp[j], IDX_W'(j)} < bestKey)) begin
        selFound = 1'b1;
        bestKey  = {grp[j], IDX_W'(j)};
        selIdx   = IDX_W'(j);
      end
    end
  end

  assign outIsRead = isRd[selIdx];
  assign outAddr   = addr[selIdx];
  assign outTag    = tag[selIdx];
  assign fullNext  = (count == CNT_W'(DEPTH - 1));
  assign lastLeft  = (emitCnt + CNT_W'(1) == count);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      emitCnt <= '0;
      done    <= '0;
      for (int j = 0; j < DEPTH; j++) begin
        isRd[j] <= 1'b0;
        addr[j] <= '0;
        tag[j]  <= '0;
      end
    end else if (stb.clear) begin
      count   <= '0;
      emitCnt <= '0;
      done    <= '0;
    end else begin
      if (stb.load) begin
        isRd[count[IDX_W-1:0]] <= inIsRead;
        addr[count[IDX_W-1:0]] <= inAddr;
        tag[count[IDX_W-1:0]]  <= inTag;
        count <= count + CNT_W'(1);
      end
      if (stb.emit) begin
        done[selIdx] <= 1'b1;
        emitCnt      <= emitCnt + CNT_W'(1);
      end
    end
  end

  // hazard monitor: any older unsent write sharing the selected read's low bits
  logic rawPending;
  always_comb begin
    rawPending = 1'b0;
    for (int j = 0; j < DEPTH; j++)
      if (IDX_W'(j) < selIdx && !done[j] && !isRd[j] &&
          addr[j][CMP_W-1:0] == addr[selIdx][CMP_W-1:0])
        rawPending = 1'b1;
  end

  assert_raw_safe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emit && isRd[selIdx]) |-> !rawPending);
  assert_load_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> (emitCnt == '0 && done == '0));
  assert_emit_live_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.emit |-> selFound);
  assert_set_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> (count < CNT_W'(DEPTH)));
endmodule

// File: rtl/rd_first_reorder.sv
module rd_first_reorder
  import rfo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 4,
  parameter int CMP_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inIsRead,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [TAG_W-1:0]  inTag,
  input  logic              inLast,
  output logic              outValid,
  input  logic              outReady,
  output logic              outIsRead,
  output logic [ADDR_W-1:0] outAddr,
  output logic [TAG_W-1:0]  outTag,
  output logic              outLast
);
  rfStrobe_t stb;
  logic fullNext, lastLeft;

  rfo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .outReady(outReady), .fullNext(fullNext), .lastLeft(lastLeft),
    .inReady(inReady), .outValid(outValid), .outLast(outLast), .stb(stb)
  );

  rfo_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .CMP_W(CMP_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inIsRead(inIsRead), .inAddr(inAddr),
    .inTag(inTag), .fullNext(fullNext), .lastLeft(lastLeft),
    .outIsRead(outIsRead), .outAddr(outAddr), .outTag(outTag)
  );

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outTag) && $stable(outAddr)
                                 && $stable(outIsRead) && $stable(outLast)));
endmodule

// File: tb/rd_first_reorder_bench.sv
`timescale 1ns/1ps
module rd_first_reorder_bench;
  localparam int DEPTH = 8, ADDR_W = 8, TAG_W = 4, CMP_W = 4;

  logic clk = 0, rstN = 0;
  logic inValid = 0, inIsRead = 0, inLast = 0, outReady = 0;
  logic [ADDR_W-1:0] inAddr = '0;
  logic [TAG_W-1:0]  inTag = '0;
  logic inReady, outValid, outIsRead, outLast;
  logic [ADDR_W-1:0] outAddr;
  logic [TAG_W-1:0]  outTag;

  int checks = 0, errors = 0;

  logic              rdA [DEPTH];
  logic [ADDR_W-1:0] adA [DEPTH];
  logic [TAG_W-1:0]  tgA [DEPTH];
  logic [TAG_W-1:0]  expA [DEPTH];

  always #10 clk = ~clk;

  rd_first_reorder #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .CMP_W(CMP_W)) u_rd_first_reorder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inIsRead(inIsRead),
    .inAddr(inAddr), .inTag(inTag), .inLast(inLast), .outValid(outValid),
    .outReady(outReady), .outIsRead(outIsRead), .outAddr(outAddr), .outTag(outTag),
    .outLast(outLast)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setE(input int i, input logic r, input int a, input int t, input int e);
    rdA[i] = r; adA[i] = ADDR_W'(a); tgA[i] = TAG_W'(t); expA[i] = TAG_W'(e);
  endtask

  task automatic sendSet(input int n, input bit useLast);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1; inIsRead = rdA[i]; inAddr = adA[i]; inTag = tgA[i];
      inLast = useLast && (i == n - 1);
      while (!inReady) @(negedge clk);
    end
    @(negedge clk);
    inValid = 0; inLast = 0;
  endtask

  task automatic collect(input int n, input string req, input bit stall);
    for (int i = 0; i < n; i++) begin
      while (!outValid) @(negedge clk);
      if (stall && i == 0) begin
        logic [TAG_W-1:0] held;
        held = outTag;
        repeat (3) @(negedge clk);
        check(outValid && outTag == held, "R8 stall hold", int'(outTag), int'(held));
      end
      check(outTag == expA[i], req, int'(outTag), int'(expA[i]));
      check(outLast == (i == n - 1), "R9 last flag", int'(outLast), int'(i == n - 1));
      if (i == 0) check(!inReady, "R9 no accept while emitting", int'(inReady), 0);
      outReady = 1;
      @(negedge clk);
    end
    outReady = 0;
    check(inReady && !outValid, "R9 ready after set", int'(inReady), 1);
  endtask

  task automatic testExample();
    setE(0, 0, 1, 1, 2); setE(1, 0, 2, 2, 4); setE(2, 0, 3, 3, 5);
    setE(3, 0, 2, 4, 3); setE(4, 1, 2, 5, 6); setE(5, 1, 3, 6, 1);
    sendSet(6, 1);
    collect(6, "R3 R4 R5 grouped order", 1);
  endtask

  task automatic testNoReads();
    setE(0, 0, 5, 7, 7); setE(1, 0, 5, 3, 3); setE(2, 0, 6, 9, 9); setE(3, 0, 5, 1, 1);
    sendSet(4, 1);
    collect(4, "R6 write-only passthrough", 0);
  endtask

  task automatic testAllReads();
    setE(0, 1, 4, 1, 1); setE(1, 1, 4, 2, 2); setE(2, 1, 7, 3, 3);
    sendSet(3, 1);
    collect(3, "R4 read-only order", 0);
  endtask

  task automatic testNarrowCompare();
    setE(0, 0, 'h15, 1, 1); setE(1, 0, 'h27, 2, 3); setE(2, 1, 'h35, 3, 2);
    sendSet(3, 1);
    collect(3, "R7 low-bit match", 0);
  endtask

  task automatic testRawOrder();
    setE(0, 1, 5, 1, 1); setE(1, 0, 5, 2, 2); setE(2, 1, 5, 3, 3); setE(3, 0, 9, 4, 4);
    sendSet(4, 1);
    collect(4, "R2 older write first", 0);
  endtask

  task automatic testFullSet();
    setE(0, 0, 1, 0, 1); setE(1, 0, 2, 1, 4); setE(2, 0, 3, 2, 0); setE(3, 0, 4, 3, 5);
    setE(4, 1, 2, 4, 6); setE(5, 0, 1, 5, 2); setE(6, 1, 1, 6, 3); setE(7, 0, 7, 7, 7);
    sendSet(8, 0);
    check(!inReady && outValid, "R10 close at full", int'(inReady), 0);
    collect(8, "R10 R3 R5 full set order", 0);
  endtask

  task automatic testSingle();
    setE(0, 1, 2, 9, 9);
    sendSet(1, 1);
    collect(1, "R9 single entry", 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!outValid && inReady, "R1 reset state", int'(outValid), 0);
    testExample();
    testNoReads();
    testAllReads();
    testNarrowCompare();
    testRawOrder();
    testFullSet();
    testSingle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule